// File: doc/BRIEF.md
# Stack Access Queue with Store Forwarding and Pairwise Write Combining

This block sits in the local-variable memory pipeline of a wide-issue core. Memory instructions already classified as stack-frame accesses are handed to it one per cycle. Each one is described by its kind (load or store), its byte offset from the stack pointer, a stack-pointer epoch, store data and a load tag. The queue keeps them in program order and hands them to a small local cache through one request port that can carry one word or two adjacent words.

Dependences are resolved on offsets rather than full addresses. A load that finds an older queued store with the same offset, in the same epoch, takes that store's data at once and never reaches the cache. The offset comparison is only meaningful inside a single stack-pointer epoch. A load therefore skips forwarding whenever any queued store belongs to another epoch, and waits in order for the cache instead. At the head of the queue, two consecutive stores to neighbouring words are merged into one paired write. This saves a cache slot whenever local-variable bandwidth is scarce.

Top module: `stack_access_queue`

## Requirements
- R1: After reset the queue is empty, `enqReady` is 1, and `reqValid` and `ldValid` are 0.
- R2: An entry is accepted on a clock edge where `enqValid` and `enqReady` are both 1. `enqReady` is 0 while DEPTH entries are held, and also in any cycle where `rspValid` is 1.
- R3: Queued entries reach the request port in enqueue order. A request carries the head entry's epoch on `reqEpoch`. `reqWrite` is 1 for a store and 0 for a load.
- R4: A load is forwarded when it is accepted, some queued store has the same epoch and the same offset, and no queued store has a different epoch. In that case the next cycle shows `ldValid`=1, `ldFwd`=1 and the load's tag. The load is not queued and makes no cache request.
- R5: When several queued stores match a forwarded load, `ldData` is the data of the most recently enqueued one.
- R6: A load that is not forwarded is queued, even when its offset matches a store. This includes loads blocked by a store of a different epoch. Such a load is later served only by a cache read.
- R7: A load at the head issues one read with `reqWrite`=0, `reqPair`=0, its own offset, and `reqData0`=`reqData1`=0. After that read is accepted, no request is raised until `rspValid` arrives. The cycle after `rspValid`, the port shows `ldValid`=1, `ldFwd`=0, `ldData` equal to `rspData`, and the load's tag. The load then leaves the queue.
- R8: When the two oldest entries are both stores of the same epoch and their offsets, taken as unsigned numbers, differ by exactly 4, one request is made with `reqPair`=1. `reqOffset` is the lower offset, `reqData0` is the data for the lower offset and `reqData1` the data for the higher one. Acceptance removes both entries.
- R9: Otherwise a store at the head is sent alone with `reqPair`=0 and `reqData1`=0. This covers a lone store, a load as second entry, a different epoch, equal or non-neighbouring offsets, and offsets such as 4092 and 0 that only touch across the offset range wrap.
- R10: Once `reqValid` is 1, it stays 1 until a cycle in which `reqReady` is 1.
- R11: `rspValid` in a cycle where no read is outstanding produces no load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enqValid | input | 1 | New access offered |
| enqReady | output | 1 | Queue can take the offered access |
| enqIsStore | input | 1 | 1 = store, 0 = load |
| enqOffset | input | OFF_W | Byte offset from the stack pointer |
| enqEpoch | input | EPOCH_W | Stack-pointer epoch of the access |
| enqData | input | DATA_W | Store data |
| enqTag | input | TAG_W | Load identifier returned with the result |
| ldValid | output | 1 | Load result valid (one-cycle pulse) |
| ldTag | output | TAG_W | Tag of the completed load |
| ldData | output | DATA_W | Load value |
| ldFwd | output | 1 | 1 = value came from a queued store |
| reqValid | output | 1 | Cache request present |
| reqReady | input | 1 | Cache accepts the request |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqPair | output | 1 | Request covers two neighbouring words |
| reqEpoch | output | EPOCH_W | Epoch of the request |
| reqOffset | output | OFF_W | Lowest byte offset covered |
| reqData0 | output | DATA_W | Write data for `reqOffset` |
| reqData1 | output | DATA_W | Write data for `reqOffset`+4 in a pair |
| rspValid | input | 1 | Read data returned by the cache |
| rspData | input | DATA_W | Returned read data |

## Verification
Store-then-load sequences at one offset show whether forwarding happens at all. Repeated stores to the same offset show whether the youngest match is picked over an older one. A load whose epoch differs from a queued store shows that forwarding is refused and the load goes to a cache read. Store pairs at offsets 4/8 and 24/20 show whether combining works and whether the data lanes are swapped correctly, while epoch changes, a 4092/0 pair and load-interleaved stores must stay single writes. A long random mix with a stalling cache, unsolicited responses and full-queue back-pressure separates ordering and hand-off faults that the directed cases cannot reach.

// File: rtl/saq_pkg.sv
package saq_pkg;

  // bytes per cache word; neighbouring words differ by this offset
  localparam int unsigned WORD_BYTES = 4;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic push;      // write the offered access at the tail
    logic popOne;    // retire the head entry
    logic popTwo;    // retire the head and the entry behind it
    logic fwdLoad;   // capture forwarded store data as a load result
    logic cacheLoad; // capture cache read data as a load result
    logic isWrite;   // request is a write
    logic isPair;    // request covers two neighbouring words
    logic swapPair;  // second entry holds the lower offset
  } saq_ctrl_t;

endpackage

// File: rtl/saq_datapath.sv
module saq_datapath
  import saq_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EPOCH_W = 4,
  parameter int unsigned TAG_W   = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  saq_ctrl_t          ctrl,
  input  logic               enqIsStore,
  input  logic [OFF_W-1:0]   enqOffset,
  input  logic [EPOCH_W-1:0] enqEpoch,
  input  logic [DATA_W-1:0]  enqData,
  input  logic [TAG_W-1:0]   enqTag,
  input  logic [DATA_W-1:0]  rspData,
  output logic [CNT_W-1:0]   occupancy,
  output logic               fwdHit,
  output logic               headIsStore,
  output logic               nextIsStore,
  output logic [OFF_W-1:0]   headOff,
  output logic [OFF_W-1:0]   nextOff,
  output logic [EPOCH_W-1:0] headEpoch,
  output logic [EPOCH_W-1:0] nextEpoch,
  output logic [EPOCH_W-1:0] reqEpoch,
  output logic [OFF_W-1:0]   reqOffset,
  output logic [DATA_W-1:0]  reqData0,
  output logic [DATA_W-1:0]  reqData1,
  output logic               ldValid,
  output logic [TAG_W-1:0]   ldTag,
  output logic [DATA_W-1:0]  ldData,
  output logic               ldFwd
);

  logic [PTR_W-1:0] headPtr, tailPtr, nextPtr;
  logic [CNT_W-1:0] countQ;

  logic [DEPTH-1:0]   entValid;
  logic [DEPTH-1:0]   entIsStore;
  logic [OFF_W-1:0]   entOff   [DEPTH];
  logic [EPOCH_W-1:0] entEpoch [DEPTH];
  logic [DATA_W-1:0]  entData  [DEPTH];
  logic [TAG_W-1:0]   entTag   [DEPTH];

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nextPtr = incPtr(headPtr);

  // entry storage, one register set per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic               vQ, sQ;
    logic [OFF_W-1:0]   oQ;
    logic [EPOCH_W-1:0] eQ;
    logic [DATA_W-1:0]  dQ;
    logic [TAG_W-1:0]   tQ;
    logic wrHere, clrHere;

    assign wrHere  = ctrl.push && (tailPtr == PTR_W'(g));
    assign clrHere = ((ctrl.popOne || ctrl.popTwo) && (headPtr == PTR_W'(g))) ||
                     (ctrl.popTwo && (nextPtr == PTR_W'(g)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        sQ <= 1'b0;
        oQ <= '0;
        eQ <= '0;
        dQ <= '0;
        tQ <= '0;
      end else begin
        if (clrHere) vQ <= 1'b0;
        if (wrHere) begin
          vQ <= 1'b1;
          sQ <= enqIsStore;
          oQ <= enqOffset;
          eQ <= enqEpoch;
          dQ <= enqData;
          tQ <= enqTag;
        end
      end
    end

    assign entValid[g]   = vQ;
    assign entIsStore[g] = sQ;
    assign entOff[g]     = oQ;
    assign entEpoch[g]   = eQ;
    assign entData[g]    = dQ;
    assign entTag[g]     = tQ;
  end

  // pointers and occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      countQ  <= '0;
    end else begin
      if (ctrl.push) tailPtr <= incPtr(tailPtr);
      if (ctrl.popTwo)      headPtr <= incPtr(nextPtr);
      else if (ctrl.popOne) headPtr <= nextPtr;
      countQ <= countQ + CNT_W'(ctrl.push) - CNT_W'(ctrl.popOne)
                - (ctrl.popTwo ? CNT_W'(2) : CNT_W'(0));
    end
  end

  assign occupancy = countQ;

  // offset match over the queue, scanned oldest to youngest
  logic               blockedByEpoch, offsetHit;
  logic [DATA_W-1:0]  fwdData;

  always_comb begin
    blockedByEpoch = 1'b0;
    offsetHit      = 1'b0;
    fwdData        = '0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [PTR_W-1:0] idx;
      idx = PTR_W'((int'(headPtr) + a) % DEPTH);
      if (entValid[idx] && entIsStore[idx]) begin
        if (entEpoch[idx] != enqEpoch) begin
          blockedByEpoch = 1'b1;
        end else if (entOff[idx] == enqOffset) begin
          offsetHit = 1'b1;
          fwdData   = entData[idx];
        end
      end
    end
  end

  assign fwdHit = offsetHit && !blockedByEpoch;

  // head and second-oldest views
  assign headIsStore = entIsStore[headPtr];
  assign nextIsStore = entIsStore[nextPtr];
  assign headOff     = entOff[headPtr];
  assign nextOff     = entOff[nextPtr];
  assign headEpoch   = entEpoch[headPtr];
  assign nextEpoch   = entEpoch[nextPtr];

  // request formatting
  always_comb begin
    reqEpoch  = entEpoch[headPtr];
    reqOffset = entOff[headPtr];
    reqData0  = '0;
    reqData1  = '0;
    if (ctrl.isWrite) begin
      if (!ctrl.isPair) begin
        reqData0 = entData[headPtr];
      end else if (!ctrl.swapPair) begin
        reqData0 = entData[headPtr];
        reqData1 = entData[nextPtr];
      end else begin
        reqOffset = entOff[nextPtr];
        reqData0  = entData[nextPtr];
        reqData1  = entData[headPtr];
      end
    end
  end

  // load result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldValid <= 1'b0;
      ldTag   <= '0;
      ldData  <= '0;
      ldFwd   <= 1'b0;
    end else begin
      ldValid <= ctrl.fwdLoad || ctrl.cacheLoad;
      if (ctrl.fwdLoad) begin
        ldTag  <= enqTag;
        ldData <= fwdData;
        ldFwd  <= 1'b1;
      end else if (ctrl.cacheLoad) begin
        ldTag  <= entTag[headPtr];
        ldData <= rspData;
        ldFwd  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/saq_control.sv
module saq_control
  import saq_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned EPOCH_W = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enqValid,
  input  logic               enqIsStore,
  input  logic               fwdHit,
  input  logic [CNT_W-1:0]   occupancy,
  input  logic               headIsStore,
  input  logic               nextIsStore,
  input  logic [OFF_W-1:0]   headOff,
  input  logic [OFF_W-1:0]   nextOff,
  input  logic [EPOCH_W-1:0] headEpoch,
  input  logic [EPOCH_W-1:0] nextEpoch,
  input  logic               reqReady,
  input  logic               rspValid,
  output saq_ctrl_t          ctrl,
  output logic               enqReady,
  output logic               reqValid
);

  localparam logic [OFF_W:0] STEP = (OFF_W + 1)'(WORD_BYTES);

  logic waitRsp;
  logic enqFire, headPresent, twoPresent;
  logic nextAbove, nextBelow, canPair, reqFire;

  assign enqReady = (occupancy < CNT_W'(DEPTH)) && !rspValid;
  assign enqFire  = enqValid && enqReady;

  assign headPresent = (occupancy != '0);
  assign twoPresent  = (occupancy >= CNT_W'(2));

  // neighbour test done one bit wider so the offset range never wraps
  assign nextAbove = ({1'b0, headOff} + STEP) == {1'b0, nextOff};
  assign nextBelow = ({1'b0, nextOff} + STEP) == {1'b0, headOff};
  assign canPair   = twoPresent && headIsStore && nextIsStore &&
                     (headEpoch == nextEpoch) && (nextAbove || nextBelow);

  assign reqValid = headPresent && (headIsStore || !waitRsp);
  assign reqFire  = reqValid && reqReady;

  always_comb begin
    ctrl           = '0;
    ctrl.fwdLoad   = enqFire && !enqIsStore && fwdHit;
    ctrl.push      = enqFire && !ctrl.fwdLoad;
    ctrl.isWrite   = headIsStore;
    ctrl.isPair    = canPair;
    ctrl.swapPair  = canPair && nextBelow;
    ctrl.cacheLoad = waitRsp && rspValid;
    ctrl.popTwo    = reqFire && canPair;
    ctrl.popOne    = (reqFire && headIsStore && !canPair) || ctrl.cacheLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitRsp <= 1'b0;
    end else if (reqFire && !headIsStore) begin
      waitRsp <= 1'b1;
    end else if (waitRsp && rspValid) begin
      waitRsp <= 1'b0;
    end
  end

endmodule

// File: rtl/stack_access_queue.sv
module stack_access_queue
  import saq_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EPOCH_W = 4,
  parameter int unsigned TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enqValid,
  output logic               enqReady,
  input  logic               enqIsStore,
  input  logic [OFF_W-1:0]   enqOffset,
  input  logic [EPOCH_W-1:0] enqEpoch,
  input  logic [DATA_W-1:0]  enqData,
  input  logic [TAG_W-1:0]   enqTag,
  output logic               ldValid,
  output logic [TAG_W-1:0]   ldTag,
  output logic [DATA_W-1:0]  ldData,
  output logic               ldFwd,
  output logic               reqValid,
  input  logic               reqReady,
  output logic               reqWrite,
  output logic               reqPair,
  output logic [EPOCH_W-1:0] reqEpoch,
  output logic [OFF_W-1:0]   reqOffset,
  output logic [DATA_W-1:0]  reqData0,
  output logic [DATA_W-1:0]  reqData1,
  input  logic               rspValid,
  input  logic [DATA_W-1:0]  rspData
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  saq_ctrl_t          ctrl;
  logic [CNT_W-1:0]   occupancy;
  logic               fwdHit, headIsStore, nextIsStore;
  logic [OFF_W-1:0]   headOff, nextOff;
  logic [EPOCH_W-1:0] headEpoch, nextEpoch;

  saq_datapath #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .EPOCH_W(EPOCH_W), .TAG_W(TAG_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .enqIsStore(enqIsStore), .enqOffset(enqOffset), .enqEpoch(enqEpoch),
    .enqData(enqData), .enqTag(enqTag), .rspData(rspData),
    .occupancy(occupancy), .fwdHit(fwdHit),
    .headIsStore(headIsStore), .nextIsStore(nextIsStore),
    .headOff(headOff), .nextOff(nextOff),
    .headEpoch(headEpoch), .nextEpoch(nextEpoch),
    .reqEpoch(reqEpoch), .reqOffset(reqOffset),
    .reqData0(reqData0), .reqData1(reqData1),
    .ldValid(ldValid), .ldTag(ldTag), .ldData(ldData), .ldFwd(ldFwd)
  );

  saq_control #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .EPOCH_W(EPOCH_W)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqIsStore(enqIsStore), .fwdHit(fwdHit),
    .occupancy(occupancy),
    .headIsStore(headIsStore), .nextIsStore(nextIsStore),
    .headOff(headOff), .nextOff(nextOff),
    .headEpoch(headEpoch), .nextEpoch(nextEpoch),
    .reqReady(reqReady), .rspValid(rspValid),
    .ctrl(ctrl), .enqReady(enqReady), .reqValid(reqValid)
  );

  assign reqWrite = ctrl.isWrite;
  assign reqPair  = ctrl.isPair;

endmodule

// File: rtl/saq_checker.sv
module saq_checker #(
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enqValid,
  input logic             enqReady,
  input logic             enqIsStore,
  input logic             rspValid,
  input logic             ldValid,
  input logic             ldFwd,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic             reqPair,
  input logic [CNT_W-1:0] occupancy
);

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  // R8
  pair_only_writes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPair) |-> reqWrite);

  // R4
  fwd_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldFwd) |-> $past(enqValid && enqReady && !enqIsStore));

  // R7
  cache_result_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !ldFwd) |-> $past(rspValid));

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);

  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> !reqValid);

endmodule

bind stack_access_queue saq_checker #(.DEPTH(DEPTH)) u_saq_checker (
  .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
  .enqIsStore(enqIsStore), .rspValid(rspValid), .ldValid(ldValid),
  .ldFwd(ldFwd), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqPair(reqPair), .occupancy(occupancy)
);

// File: tb/stack_access_queue_bench.sv
module stack_access_queue_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int OFF_W = 12;
  localparam int DATA_W = 32;
  localparam int EPOCH_W = 4;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0, enqIsStore = 1'b0;
  logic [OFF_W-1:0] enqOffset = '0;
  logic [EPOCH_W-1:0] enqEpoch = '0;
  logic [DATA_W-1:0] enqData = '0;
  logic [TAG_W-1:0] enqTag = '0;
  logic reqReady = 1'b0, rspValid = 1'b0;
  logic [DATA_W-1:0] rspData = '0;
  logic enqReady, ldValid, ldFwd, reqValid, reqWrite, reqPair;
  logic [TAG_W-1:0] ldTag;
  logic [DATA_W-1:0] ldData, reqData0, reqData1;
  logic [EPOCH_W-1:0] reqEpoch;
  logic [OFF_W-1:0] reqOffset;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_access_queue #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .DATA_W(DATA_W), .EPOCH_W(EPOCH_W), .TAG_W(TAG_W)
  ) u_stack_access_queue (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
    .enqIsStore(enqIsStore), .enqOffset(enqOffset), .enqEpoch(enqEpoch),
    .enqData(enqData), .enqTag(enqTag), .ldValid(ldValid), .ldTag(ldTag),
    .ldData(ldData), .ldFwd(ldFwd), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqPair(reqPair), .reqEpoch(reqEpoch),
    .reqOffset(reqOffset), .reqData0(reqData0), .reqData1(reqData1),
    .rspValid(rspValid), .rspData(rspData)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    bit isStore;
    int off;
    int epoch;
    logic [31:0] data;
    int tag;
  } ent_t;

  ent_t mq[$];
  bit mWait = 1'b0;
  bit eLdValid = 1'b0, eLdFwd = 1'b0;
  logic [31:0] eLdData = '0;
  int eLdTag = 0;
  int accSeen = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      mq.delete();
      mWait = 1'b0;
      eLdValid = 1'b0;
    end else begin
      bit eRdy, eReq, ePair, eSwap, blocked, hit, enqFire, newLd, nFwd;
      int eOff, nTag;
      logic [31:0] eD0, eD1, hitData, nData;

      eRdy = (mq.size() < DEPTH) && !rspValid;
      eReq = (mq.size() > 0) && (mq.size() > 0 ? (mq[0].isStore || !mWait) : 1'b0);
      ePair = 1'b0; eSwap = 1'b0;
      if (mq.size() >= 2)
        if (mq[0].isStore && mq[1].isStore && mq[0].epoch == mq[1].epoch) begin
          if (mq[1].off == mq[0].off + 4) ePair = 1'b1;
          if (mq[0].off == mq[1].off + 4) begin ePair = 1'b1; eSwap = 1'b1; end
        end
      eOff = 0; eD0 = '0; eD1 = '0;
      if (eReq) begin
        eOff = mq[0].off;
        if (mq[0].isStore) eD0 = mq[0].data;
        if (ePair) begin
          if (eSwap) begin eOff = mq[1].off; eD0 = mq[1].data; eD1 = mq[0].data; end
          else eD1 = mq[1].data;
        end
      end

      chk("R2", "enqReady", 64'(enqReady), 64'(eRdy));
      chk("R3 R7 R10", "reqValid", 64'(reqValid), 64'(eReq));
      if (eReq) begin
        chk("R3", "reqWrite", 64'(reqWrite), 64'(mq[0].isStore));
        chk("R8 R9", "reqPair", 64'(reqPair), 64'(ePair));
        chk("R3 R8", "reqOffset", 64'(reqOffset), 64'(eOff));
        chk("R3", "reqEpoch", 64'(reqEpoch), 64'(mq[0].epoch));
        chk("R3 R7 R8", "reqData0", 64'(reqData0), 64'(eD0));
        chk("R8 R9", "reqData1", 64'(reqData1), 64'(eD1));
      end
      chk("R4 R7 R11", "ldValid", 64'(ldValid), 64'(eLdValid));
      if (eLdValid) begin
        chk("R4 R6", "ldFwd", 64'(ldFwd), 64'(eLdFwd));
        chk("R5 R7", "ldData", 64'(ldData), 64'(eLdData));
        chk("R4 R7", "ldTag", 64'(ldTag), 64'(eLdTag));
      end

      // advance to the state after the coming edge
      enqFire = enqValid && eRdy;
      blocked = 1'b0; hit = 1'b0; hitData = '0;
      if (enqFire && !enqIsStore)
        foreach (mq[i])
          if (mq[i].isStore) begin
            if (mq[i].epoch != int'(enqEpoch)) blocked = 1'b1;
            else if (mq[i].off == int'(enqOffset)) begin hit = 1'b1; hitData = mq[i].data; end
          end
      newLd = 1'b0; nFwd = 1'b0; nData = '0; nTag = 0;
      if (eReq && reqReady) begin
        if (mq[0].isStore) begin
          void'(mq.pop_front());
          if (ePair) void'(mq.pop_front());
        end else begin
          mWait = 1'b1;
          accSeen++;
        end
      end else if (mWait && rspValid) begin
        newLd = 1'b1; nData = rspData; nTag = mq[0].tag;
        void'(mq.pop_front());
        mWait = 1'b0;
      end
      if (enqFire) begin
        if (!enqIsStore && hit && !blocked) begin
          newLd = 1'b1; nFwd = 1'b1; nData = hitData; nTag = int'(enqTag);
        end else begin
          ent_t e;
          e.isStore = enqIsStore; e.off = int'(enqOffset); e.epoch = int'(enqEpoch);
          e.data = enqData; e.tag = int'(enqTag);
          mq.push_back(e);
        end
      end
      eLdValid = newLd; eLdFwd = nFwd; eLdData = nData; eLdTag = nTag;
    end
  end

  // ---------------- cache model ----------------
  int readyMode = 0;   // 0 never, 1 always, 2 random
  bit spurious = 1'b0;
  int accUsed = 0;
  bit rdPend = 1'b0;
  int rdLat = 0;

  always begin
    @(posedge clk); #1;
    if (!rstN) begin
      reqReady = 1'b0; rspValid = 1'b0; rdPend = 1'b0; accUsed = accSeen;
    end else begin
      reqReady = (readyMode == 1) ? 1'b1 : (readyMode == 2) ? (($urandom % 3) != 0) : 1'b0;
      rspValid = 1'b0;
      if (rdPend) begin
        if (rdLat == 0) begin rspValid = 1'b1; rspData = $urandom; rdPend = 1'b0; end
        else rdLat--;
      end else if (spurious && accUsed == accSeen && ($urandom % 8) == 0) begin
        rspValid = 1'b1; rspData = $urandom;
      end
      if (accUsed != accSeen) begin
        accUsed = accSeen; rdPend = 1'b1; rdLat = $urandom % 3;
      end
    end
  end

  // ---------------- stimulus ----------------
  int tagCnt = 0;

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic enq(input bit st, input int off, input int ep, input logic [31:0] d);
    enqValid = 1'b1; enqIsStore = st; enqOffset = OFF_W'(off);
    enqEpoch = EPOCH_W'(ep); enqData = d; enqTag = TAG_W'(tagCnt);
    tagCnt = (tagCnt + 1) % 16;
    do @(negedge clk); while (!enqReady);
    @(posedge clk); #1;
    enqValid = 1'b0;
  endtask

  task automatic drain();
    readyMode = 1;
    while (mq.size() != 0 || mWait) idle(1);
    idle(4);
  endtask

  initial begin
    rstN = 1'b0;
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "enqReady after reset", 64'(enqReady), 64'd1);
    chk("R1", "reqValid after reset", 64'(reqValid), 64'd0);
    chk("R1", "ldValid after reset", 64'(ldValid), 64'd0);
    @(posedge clk); #1;

    // R4 R5 R6: forwarding, youngest match, epoch block
    readyMode = 0;
    enq(1, 8, 0, 32'hAAAA_0001);
    enq(0, 8, 0, 0);
    enq(1, 8, 0, 32'hBBBB_0002);
    enq(0, 8, 0, 0);
    enq(0, 12, 0, 0);
    enq(1, 16, 1, 32'hCCCC_0003);
    enq(0, 8, 1, 0);
    idle(3);
    drain();

    // R8 R9: pairing, swapped pairing and refused pairs
    readyMode = 0;
    enq(1, 4, 2, 32'h1111_0004);
    enq(1, 8, 2, 32'h2222_0008);
    enq(1, 24, 2, 32'h3333_0018);
    enq(1, 20, 2, 32'h4444_0014);
    enq(1, 40, 2, 32'h5555_0028);
    enq(1, 44, 3, 32'h6666_002C);
    idle(2);
    drain();
    readyMode = 0;
    enq(1, 4092, 3, 32'h7777_0FFC);
    enq(1, 0, 3, 32'h8888_0000);
    enq(1, 60, 3, 32'h9999_003C);
    enq(0, 64, 3, 0);
    enq(1, 100, 3, 32'hAAAA_0064);
    enq(1, 100, 3, 32'hBBBB_0064);
    drain();
    readyMode = 0;
    enq(1, 200, 4, 32'hCAFE_00C8);
    idle(3);
    drain();

    // R2: fill the queue, then release the cache
    readyMode = 0;
    for (int i = 0; i < DEPTH; i++) enq(1, 300 + 12 * i, 5, 32'hF000_0000 + i);
    fork
      begin repeat (6) @(posedge clk); readyMode = 1; end
    join_none
    enq(1, 500, 5, 32'hF000_00FF);
    drain();

    // R3 R7 R10 R11: random mix with a stalling cache and stray responses
    readyMode = 2;
    spurious = 1'b1;
    begin
      int ep;
      ep = 6;
      for (int i = 0; i < 800; i++) begin
        int r;
        r = $urandom % 16;
        if (r == 0) ep = (ep + 1) % 16;
        if (r < 3) idle(1);
        else enq(($urandom % 2) == 1, ($urandom % 8) * 4, ep, $urandom);
      end
    end
    spurious = 1'b0;
    drain();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule